// File: doc/BRIEF.md
# Two-Channel Bus Selector with I2C Control

This block is the digital core of an I2C-programmed switch that connects an upstream two-wire bus to any combination of two downstream bus segments. The upstream master addresses the block and writes one control byte. The low bits of that byte choose which downstream segments are connected. The same master can read the byte back. The readback also carries the live state of the two downstream interrupt lines. The block drives no analog switch. It presents one logic enable per channel, and a pass-gate stage outside the block acts on those enables.

The upstream clock and data lines are sampled on a fast system clock. A START or STOP is recognised wherever it occurs. The block answers the 7-bit address {1110 0, strap1, strap0}, where two strap pins supply the two low bits. A new channel selection takes effect only when the STOP that closes the write arrives. This keeps a segment from being switched in or out in the middle of the transfer that selects it.

The two active-low interrupt inputs are merged into one output. That output can only pull a shared line low or leave it released. The reset pin and power-up both clear the selection.

Top module: `i2c_chan_sel`

## Requirements
- R1: The block answers only the 7-bit address {5'b11100, addr_pin[1], addr_pin[0]}. When the address matches, it pulls SDA low for the ninth clock of the address byte.
- R2: While rst_n is low, and on the first clock after it goes low, chan_en is 2'b00 and sda_pull is 0. The bus state machine restarts idle. The same holds at power-up, because rst_n starts low.
- R3: A byte written after a matching write address is acknowledged. Its bit 0 enables channel 0 and its bit 1 enables channel 1. Any of the four combinations is accepted, including none and both.
- R4: Bits 7:6 and 3:2 of the control byte ignore writes and always read as 0. Bits 5:4 cannot be changed by a write.
- R5: chan_en keeps its old value throughout a write transfer. It takes the written value on the STOP that ends the transfer, within four clocks of the STOP being visible on the pins.
- R6: A read after a matching read address returns {2'b00, int1, int0, 2'b00, en1, en0}, most significant bit first. Here intN is 1 when irq_in_n[N] is low, and en1/en0 are the current chan_en. The same byte is returned again after each master ACK.
- R7: A master NACK after a read byte ends the read. The block then leaves SDA released for any further clocks until the next START.
- R8: irq_pull is 1 exactly when at least one irq_in_n bit is low. It follows the inputs with a latency of two clock cycles. The output can only request a pull-low, never a high drive.
- R9: A non-matching address gets no ACK. SDA stays released for the rest of that transfer, including any read bytes. chan_en is unchanged, even when a STOP follows.
- R10: sda_pull changes only after a falling SCL edge, a START or a STOP. It never changes during the high phase of an SCL bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Upstream SCL level |
| sda_in | input | 1 | Upstream SDA level (wired-AND of all drivers) |
| addr_pin | input | 2 | Address strap pins, low two address bits |
| irq_in_n | input | 2 | Active-low downstream interrupt inputs |
| sda_pull | output | 1 | 1 = pull upstream SDA low |
| chan_en | output | 2 | Channel enables, bit N connects downstream channel N |
| irq_pull | output | 1 | 1 = pull shared interrupt line low |

## Verification
A bit counter or state register that goes out of step shows up on SDA within the same byte. It appears as a missing or misplaced ACK on the ninth clock, or as read data shifted by one position, so it is visible by the next acknowledge slot. A held write that is committed early or lost shows on chan_en. An early commit changes chan_en before the STOP. A lost write leaves chan_en unchanged four clocks after the STOP. The interrupt path has no state beyond its synchronizer, so a fault there appears on irq_pull two clocks after an input edge.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int REG_W   = 8;
  localparam int IRQ_LSB = 4;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR    = 3'd1,
    ST_ADDR_AK = 3'd2,
    ST_WR_DATA = 3'd3,
    ST_WR_AK   = 3'd4,
    ST_RD_DATA = 3'd5,
    ST_RD_AK   = 3'd6,
    ST_IGNORE  = 3'd7
  } bus_state_e;
endpackage

// File: rtl/chsel_line_sync.sv
module chsel_line_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [31:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_async[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= {STAGES{RST_VAL[b]}};
      end else begin
        chain_q <= chain_d;
      end
    end

    assign q_sync[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/chsel_bus_engine.sv
module chsel_bus_engine
  import chsel_pkg::*;
#(
  parameter int BYTE_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [BYTE_W-2:0] dev_addr,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              wr_stb,
  output logic              stop_det,
  output logic              bus_evt,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  bus_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              nack_q, nack_d;
  logic              scl_p_q, sda_p_q;

  logic scl_rise, scl_fall, start_det;

  // Edge and condition detection on the synchronised lines
  always_comb begin
    scl_rise  = scl_s & ~scl_p_q;
    scl_fall  = ~scl_s & scl_p_q;
    start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
    stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
    bus_evt   = scl_fall | start_det | stop_det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
    end
  end

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    rw_d   = rw_q;
    nack_d = nack_q;
    wr_stb = 1'b0;
    if (start_det) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WR_DATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (st_q == ST_WR_DATA) begin
              st_d   = ST_WR_AK;
              wr_stb = 1'b1;
            end else if (sh_q[BYTE_W-1:1] == dev_addr) begin
              st_d = ST_ADDR_AK;
              rw_d = sh_q[0];
            end else begin
              st_d = ST_IGNORE;
            end
          end
        end
        ST_ADDR_AK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              st_d = ST_RD_DATA;
              sh_d = rd_byte;
            end else begin
              st_d = ST_WR_DATA;
            end
          end
        end
        ST_WR_AK: begin
          if (scl_fall) begin
            st_d  = ST_WR_DATA;
            cnt_d = '0;
          end
        end
        ST_RD_DATA: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              st_d = ST_RD_AK;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RD_AK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              st_d = ST_IGNORE;
            end else begin
              st_d  = ST_RD_DATA;
              sh_d  = rd_byte;
              cnt_d = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      rw_q   <= 1'b0;
      nack_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      rw_q   <= rw_d;
      nack_q <= nack_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_ADDR_AK, ST_WR_AK: sda_oe = 1'b1;
      ST_RD_DATA:           sda_oe = ~sh_q[BYTE_W-1];
      default:              sda_oe = 1'b0;
    endcase
  end

  assign wr_byte = sh_q;
endmodule

// File: rtl/chsel_ctrl_reg.sv
module chsel_ctrl_reg
  import chsel_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [REG_W-1:0]  wr_byte,
  input  logic              stop_det,
  input  logic [NUM_CH-1:0] irq_act,
  output logic [NUM_CH-1:0] ch_en,
  output logic [REG_W-1:0]  rd_byte,
  output logic              irq_pull
);
  logic [NUM_CH-1:0] en_q, en_d, pend_q, pend_d;
  logic              vld_q, vld_d, upd;
  logic              unused_bits;

  assign unused_bits = ^wr_byte[REG_W-1:NUM_CH];

  // Hold written byte until STOP, then commit
  always_comb begin
    en_d   = en_q;
    pend_d = pend_q;
    vld_d  = vld_q;
    if (wr_stb) begin
      pend_d = wr_byte[NUM_CH-1:0];
      vld_d  = 1'b1;
    end else if (stop_det && vld_q) begin
      en_d  = pend_q;
      vld_d = 1'b0;
    end
    upd = wr_stb | stop_det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      vld_q  <= 1'b0;
    end else if (upd) begin
      en_q   <= en_d;
      pend_q <= pend_d;
      vld_q  <= vld_d;
    end
  end

  // Readback byte: enables low, interrupt flags from IRQ_LSB, rest zero
  for (genvar i = 0; i < REG_W; i++) begin : g_rd
    if (i < NUM_CH) begin : g_en
      assign rd_byte[i] = en_q[i];
    end else if (i >= IRQ_LSB && i < IRQ_LSB + NUM_CH) begin : g_irq
      assign rd_byte[i] = irq_act[i-IRQ_LSB];
    end else begin : g_zero
      assign rd_byte[i] = 1'b0;
    end
  end

  assign ch_en    = en_q;
  assign irq_pull = |irq_act;
endmodule

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel
  import chsel_pkg::*;
#(
  parameter int          NUM_CH      = 2,
  parameter logic [4:0]  ADDR_HI     = 5'b11100,
  parameter int          SYNC_STAGES = 2,
  parameter int          RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [1:0]        addr_pin,
  input  logic [NUM_CH-1:0] irq_in_n,
  output logic              sda_pull,
  output logic [NUM_CH-1:0] chan_en,
  output logic              irq_pull
);
  logic [RST_STAGES-1:0] rst_chain_q;
  logic                  rst_s;
  logic                  scl_s, sda_s;
  logic [NUM_CH-1:0]     irq_n_s;
  logic [REG_W-1:0]      rd_byte, wr_byte;
  logic                  wr_stb, stop_det, bus_evt;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_chain_q <= '0;
    end else begin
      rst_chain_q <= {rst_chain_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_s = rst_chain_q[RST_STAGES-1];

  chsel_line_sync #(
    .WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(32'h3)
  ) u_bus_sync (
    .clk(clk), .rst_n(rst_s),
    .d_async({scl_in, sda_in}), .q_sync({scl_s, sda_s})
  );

  chsel_line_sync #(
    .WIDTH(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL('1)
  ) u_irq_sync (
    .clk(clk), .rst_n(rst_s),
    .d_async(irq_in_n), .q_sync(irq_n_s)
  );

  chsel_bus_engine #(.BYTE_W(REG_W)) u_engine (
    .clk(clk), .rst_n(rst_s),
    .scl_s(scl_s), .sda_s(sda_s),
    .dev_addr({ADDR_HI, addr_pin}),
    .rd_byte(rd_byte), .wr_byte(wr_byte), .wr_stb(wr_stb),
    .stop_det(stop_det), .bus_evt(bus_evt), .sda_oe(sda_pull)
  );

  chsel_ctrl_reg #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_s),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .stop_det(stop_det),
    .irq_act(~irq_n_s),
    .ch_en(chan_en), .rd_byte(rd_byte), .irq_pull(irq_pull)
  );
endmodule

// File: rtl/chsel_checker.sv
module chsel_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_s,
  input logic              sda_pull,
  input logic [NUM_CH-1:0] chan_en,
  input logic [NUM_CH-1:0] irq_in_n,
  input logic              irq_pull,
  input logic              stop_det,
  input logic              bus_evt
);
  // R2: reset clears enables and releases SDA
  a_r2_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (chan_en == '0 && !sda_pull));

  // R5: enables move only right after a STOP was seen
  a_r5_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_s)
    (chan_en != $past(chan_en)) |-> $past(stop_det));

  // R8: merged interrupt follows inputs two clocks later
  a_r8_irq_merge: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s, 2) |-> (irq_pull == !(&$past(irq_in_n, 2))));

  // R10: SDA drive changes only after SCL fall, START or STOP
  a_r10_sda_timing: assert property (@(posedge clk) disable iff (!rst_s)
    (sda_pull != $past(sda_pull)) |-> $past(bus_evt));
endmodule

bind i2c_chan_sel chsel_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_s(rst_s), .sda_pull(sda_pull),
  .chan_en(chan_en), .irq_in_n(irq_in_n), .irq_pull(irq_pull),
  .stop_det(stop_det), .bus_evt(bus_evt)
);

// File: tb/i2c_chan_sel_test.sv
module i2c_chan_sel_test;
  localparam int Q = 8;
  localparam logic [4:0] HI = 5'b11100;

  logic       clk = 1'b0;
  logic       rst_n, scl_m, sda_m;
  logic [1:0] strap, irq_n, chan_en;
  logic       sda_pull, irq_pull;
  wire        sda_line = sda_m & ~sda_pull;

  int n_chk = 0, n_fail = 0, r10_viol = 0;
  logic [1:0] exp_en;
  logic       prev_pull, prev_scl;

  always #5 clk = ~clk;

  i2c_chan_sel uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .addr_pin(strap), .irq_in_n(irq_n),
    .sda_pull(sda_pull), .chan_en(chan_en), .irq_pull(irq_pull)
  );

  // R10 monitor: SDA drive must not move while SCL stays high
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && sda_pull !== prev_pull) r10_viol++;
    prev_pull = sda_pull;
    prev_scl  = scl_m;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] en, input logic [1:0] irqn);
    return {2'b00, ~irqn[1], ~irqn[0], 2'b00, en};
  endfunction

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; w(2); scl_m = 1'b1; w(Q);
    sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0;
    end
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q/2);
    acked = ~sda_line; w(Q/2); scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl_m = 1'b1; w(Q/2); b[i] = sda_line; w(Q/2); scl_m = 1'b0;
    end
    w(1); sda_m = nack; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0;
    w(1); sda_m = 1'b1; w(Q);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d);
    logic ak;
    logic match;
    match = (a == {HI, strap});
    bus_start;
    send_byte({a, 1'b0}, ak);
    chk(match ? "R1 write address ack" : "R9 no ack on foreign address", {7'd0, ak}, {7'd0, match});
    send_byte(d, ak);
    chk(match ? "R3 data ack" : "R9 no data ack", {7'd0, ak}, {7'd0, match});
    chk("R5 enables held before STOP", {6'd0, chan_en}, {6'd0, exp_en});
    bus_stop;
    w(4);
    if (match) exp_en = d[1:0];
    chk(match ? "R3 enables after STOP" : "R9 enables unchanged", {6'd0, chan_en}, {6'd0, exp_en});
  endtask

  task automatic do_read(input logic [6:0] a);
    logic ak;
    logic match;
    logic [7:0] b;
    match = (a == {HI, strap});
    bus_start;
    send_byte({a, 1'b1}, ak);
    chk(match ? "R1 read address ack" : "R9 no read ack", {7'd0, ak}, {7'd0, match});
    recv_byte(1'b0, b);
    chk(match ? "R6 read byte" : "R9 SDA released", b, match ? exp_rd(exp_en, irq_n) : 8'hFF);
    recv_byte(1'b1, b);
    chk(match ? "R6 repeat byte after ACK" : "R9 SDA released", b, match ? exp_rd(exp_en, irq_n) : 8'hFF);
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic       ak;
    logic [6:0] a;
    int         seed;
    seed = $urandom(32'h1234ABCD);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 2'b10; irq_n = 2'b11;
    exp_en = 2'b00; prev_pull = 1'b0; prev_scl = 1'b1;
    w(5); rst_n = 1'b1; w(6);
    chk("R2 enables after reset", {6'd0, chan_en}, 8'h00);
    chk("R2 SDA released after reset", {7'd0, sda_pull}, 8'h00);
    chk("R8 no interrupt after reset", {7'd0, irq_pull}, 8'h00);

    // Directed: each enable combination
    do_write({HI, strap}, 8'h01); do_read({HI, strap});
    do_write({HI, strap}, 8'h02);
    do_write({HI, strap}, 8'h03); do_read({HI, strap});
    do_write({HI, strap}, 8'h00);
    // R4: reserved and interrupt bits ignore writes
    do_write({HI, strap}, 8'hFD);
    bus_start; send_byte({HI, strap, 1'b1}, ak); recv_byte(1'b1, b); bus_stop;
    chk("R4 reserved bits read zero", b, 8'h01);

    // R9: foreign address
    do_write({HI, ~strap}, 8'h02);
    do_read({5'b11101, strap});

    // R8: interrupt merge and latency
    for (int k = 0; k < 4; k++) begin
      logic [1:0] v;
      logic       old;
      v = 2'(k ^ 1);
      old = irq_pull;
      irq_n = v;
      w(1);
      chk("R8 one cycle: old value", {7'd0, irq_pull}, {7'd0, old});
      w(1);
      chk("R8 merged interrupt", {7'd0, irq_pull}, {7'd0, ~&v});
      do_read({HI, strap});
    end
    irq_n = 2'b11; w(3);

    // R7: NACK ends read, further clocks see released SDA
    do_write({HI, strap}, 8'h03);
    bus_start; send_byte({HI, strap, 1'b1}, ak);
    recv_byte(1'b1, b);
    chk("R7 byte before NACK", b, exp_rd(exp_en, irq_n));
    recv_byte(1'b1, b);
    chk("R7 released after NACK", b, 8'hFF);
    bus_stop;

    // Random mix
    for (int it = 0; it < 24; it++) begin
      strap = 2'($urandom);
      irq_n = 2'($urandom);
      w(4);
      a = ($urandom % 3 != 0) ? {HI, strap} : 7'($urandom);
      if ($urandom % 2 == 0) do_write(a, 8'($urandom));
      else do_read(a);
    end
    irq_n = 2'b11;

    // R2: reset in the middle of a write
    do_write({HI, strap}, 8'h03);
    bus_start; send_byte({HI, strap, 1'b0}, ak);
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); scl_m = 1'b0; w(Q);
    rst_n = 1'b0; w(2);
    chk("R2 enables cleared by reset", {6'd0, chan_en}, 8'h00);
    chk("R2 SDA released in reset", {7'd0, sda_pull}, 8'h00);
    exp_en = 2'b00;
    sda_m = 1'b1; w(2); scl_m = 1'b1; w(2); rst_n = 1'b1; w(6);
    do_read({HI, strap});

    chk("R10 SDA stable while SCL high", 8'(r10_viol), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule